// File: doc/BRIEF.md
# Boot Image Copy Engine

This block holds a short boot program in a small retention SRAM that stays powered while the embedded processor sleeps. It copies that program, one 32-bit word per clock, into the processor's instruction RAM. The host first fills the retention SRAM through an address window. It then programs three values: a source byte offset inside that SRAM, a destination byte address in instruction RAM, and a transfer length in dwords.

A copy starts in one of two ways. The host can set the go bit in the control register. Alternatively, once the arm bit is set, every power-up event starts a copy with no host write. The go bit reads back as a busy indication, so software can poll it. A status register reports completion. While a copy runs, the three transfer registers and the SRAM window are locked. This means every automatic reload repeats exactly the transfer the host programmed.

Top module: `boot_copy_engine`

## Requirements
- R1: After synchronous reset, all readable registers read 0, `copy_done` is 0 and `iram_we` is 0.
- R2: The registers are decoded on byte offsets with the two low address bits ignored. Offset 0x000 is control, with bit 31 = go/busy and bit 30 = arm. Offset 0x004 is the source byte offset and offset 0x008 is the destination address; both read back as written. Offset 0x00C is the count, which keeps only bits 8:0 and reads 0 above them. Offset 0x010 is status, with bit 0 = done.
- R3: Offsets 0x400 to 0x7FF form the retention SRAM window. A dword write there stores into word index (offset − 0x400) / 4.
- R4: A control write with bit 31 set, made while idle, starts a copy at that clock edge. Bit 31 reads 1 from the next cycle for as long as words are being written, then reads 0.
- R5: A copy of N words drives `iram_we` high for exactly N consecutive cycles, starting in the cycle after the start edge. In write cycle k, `iram_addr` = destination + 4k and `iram_wdata` = SRAM word ((source / 4) + k) mod 256.
- R6: `copy_done` and status bit 0 go to 1 when the last word has been written. They clear at the start of the next copy with a nonzero count. Busy and done are never 1 together.
- R7: A start with count 0 writes nothing. Done reads 1 and bit 31 reads 0 in the cycle after the start edge.
- R8: While arm is 1 and the engine is idle, a one-cycle pulse on `wake_evt` starts a copy using the current source, destination and count. Each further pulse repeats the same copy. With arm at 0, `wake_evt` does nothing.
- R9: A `wake_evt` pulse or a control write with bit 31 set, arriving while a copy runs, neither restarts nor lengthens it.
- R10: While a copy runs, writes to source, destination, count and the SRAM window are dropped. The values read back afterwards and the data copied later are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe for one cycle |
| host_addr | input | 12 | Host byte offset for reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational register read data at `host_addr` |
| wake_evt | input | 1 | Power-up event pulse |
| iram_we | output | 1 | Instruction RAM write enable |
| iram_addr | output | 32 | Instruction RAM byte address |
| iram_wdata | output | 32 | Instruction RAM write data |
| copy_done | output | 1 | Last copy finished |

## Verification
The assertions check several properties on every cycle. Busy and done are never high together. The destination advances by exactly four bytes between consecutive write cycles. A falling busy leaves done set. A zero count finishes without entering busy. The transfer configuration stays frozen while busy. The SRAM never receives a write during a copy, and an unarmed wake with no host start never causes activity. Only the bench scenarios can show the rest: that the copied words match the SRAM contents across a sweep of source offsets and lengths (including wrap at the end of the SRAM), that retriggers arriving mid-copy leave the write count unchanged, and that repeated wake pulses reproduce the programmed transfer.

// File: rtl/bce_pkg.sv
package bce_pkg;

    localparam int unsigned WORD_W = 32;

    // Register byte offsets
    localparam logic [31:0] OFS_CTRL = 32'h000;
    localparam logic [31:0] OFS_SRC  = 32'h004;
    localparam logic [31:0] OFS_DST  = 32'h008;
    localparam logic [31:0] OFS_CNT  = 32'h00C;
    localparam logic [31:0] OFS_STAT = 32'h010;

    localparam int unsigned CTRL_GO_BIT  = 31;
    localparam int unsigned CTRL_ARM_BIT = 30;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_SRC,
        SEL_DST,
        SEL_CNT,
        SEL_STAT,
        SEL_SRAM
    } sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] cnt;
    } copy_cfg_t;

    // Maps a host byte offset to a register or the SRAM window.
    function automatic sel_e reg_decode(input logic [31:0] a,
                                        input logic [31:0] win_base,
                                        input logic [31:0] win_bytes);
        logic [31:0] aligned;
        aligned = {a[31:2], 2'b00};
        if (a >= win_base && a < win_base + win_bytes) begin
            return SEL_SRAM;
        end
        case (aligned)
            OFS_CTRL: return SEL_CTRL;
            OFS_SRC:  return SEL_SRC;
            OFS_DST:  return SEL_DST;
            OFS_CNT:  return SEL_CNT;
            OFS_STAT: return SEL_STAT;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bce_regs.sv
module bce_regs
    import bce_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned SRAM_BASE  = 1024,
    parameter int unsigned SRAM_BYTES = 1024,
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned CNT_W      = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                busy,
    input  logic                done,
    output logic [WORD_W-1:0]   rdata,
    output logic                arm,
    output logic                host_go,
    output logic [IDX_W-1:0]    cfg_src_idx,
    output logic [WORD_W-1:0]   cfg_dst,
    output logic [CNT_W-1:0]    cfg_cnt,
    output logic                mem_we,
    output logic [IDX_W-1:0]    mem_idx,
    output logic [WORD_W-1:0]   mem_wdata
);

    localparam logic [31:0] CNT_MASK = (32'd1 << CNT_W) - 32'd1;

    copy_cfg_t   cfg;
    sel_e        sel;
    logic [31:0] addr32;
    logic [31:0] win_ofs;

    assign addr32  = 32'(addr);
    assign sel     = reg_decode(addr32, 32'(SRAM_BASE), 32'(SRAM_BYTES));
    assign win_ofs = addr32 - 32'(SRAM_BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            arm <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL: arm <= wdata[CTRL_ARM_BIT];
                SEL_SRC:  if (!busy) cfg.src <= wdata;
                SEL_DST:  if (!busy) cfg.dst <= wdata;
                SEL_CNT:  if (!busy) cfg.cnt <= wdata & CNT_MASK;
                default:  ;
            endcase
        end
    end

    assign host_go     = wr_en && (sel == SEL_CTRL) && wdata[CTRL_GO_BIT];
    assign mem_we      = wr_en && (sel == SEL_SRAM) && !busy;
    assign mem_idx     = IDX_W'(win_ofs >> 2);
    assign mem_wdata   = wdata;
    assign cfg_src_idx = IDX_W'(cfg.src >> 2);
    assign cfg_dst     = cfg.dst;
    assign cfg_cnt     = CNT_W'(cfg.cnt);

    always_comb begin
        case (sel)
            SEL_CTRL: rdata = {busy, arm, 30'd0};
            SEL_SRC:  rdata = cfg.src;
            SEL_DST:  rdata = cfg.dst;
            SEL_CNT:  rdata = cfg.cnt;
            SEL_STAT: rdata = {31'd0, done};
            default:  rdata = '0;
        endcase
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg)) else $error("transfer config changed while busy"); // R10

endmodule

// File: rtl/bce_sram.sv
module bce_sram
    import bce_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               busy,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [IDX_W-1:0]   ridx,
    output logic [WORD_W-1:0]  rd_data
);

    // Retention storage: deliberately not cleared by reset.
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rd_data = mem[ridx];

    AST_NO_SRAM_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !we) else $error("SRAM written during copy"); // R10

endmodule

// File: rtl/bce_seq.sv
module bce_seq
    import bce_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned CNT_W = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               launch,
    input  logic [IDX_W-1:0]   cfg_src_idx,
    input  logic [WORD_W-1:0]  cfg_dst,
    input  logic [CNT_W-1:0]   cfg_cnt,
    input  logic [WORD_W-1:0]  rd_data,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               busy,
    output logic               done,
    output logic               iram_we,
    output logic [WORD_W-1:0]  iram_addr,
    output logic [WORD_W-1:0]  iram_wdata
);

    logic [IDX_W-1:0]  cur_idx;
    logic [WORD_W-1:0] cur_dst;
    logic [CNT_W-1:0]  left;
    logic              start_ok;
    logic              zero_len;

    assign start_ok = launch && !busy;
    assign zero_len = (cfg_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            cur_idx <= '0;
            cur_dst <= '0;
            left    <= '0;
        end else if (start_ok) begin
            cur_idx <= cfg_src_idx;
            cur_dst <= cfg_dst;
            left    <= cfg_cnt;
            busy    <= !zero_len;
            done    <= zero_len;
        end else if (busy) begin
            cur_idx <= cur_idx + 1'b1;
            cur_dst <= cur_dst + 32'd4;
            left    <= left - 1'b1;
            if (left == CNT_W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    assign rd_idx     = cur_idx;
    assign iram_we    = busy;
    assign iram_addr  = cur_dst;
    assign iram_wdata = rd_data;

    AST_BUSY_EXCL_DONE: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done) else $error("busy and done together"); // R6

    AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done) else $error("copy ended without done"); // R6

    AST_DST_STRIDE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (iram_addr == $past(iram_addr) + 32'd4))
        else $error("destination stride broken"); // R5

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (launch && !busy && cfg_cnt == '0) |=> (!busy && done))
        else $error("zero count did not finish at once"); // R7

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        (busy && left != CNT_W'(1)) |=> busy)
        else $error("copy cut short or restarted"); // R9

endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine
    import bce_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned SRAM_BASE  = 1024,
    parameter int unsigned SRAM_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              wake_evt,
    output logic              iram_we,
    output logic [31:0]       iram_addr,
    output logic [31:0]       iram_wdata,
    output logic              copy_done
);

    localparam int unsigned DEPTH = SRAM_BYTES / 4;
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = IDX_W + 1;

    logic               busy;
    logic               done;
    logic               arm;
    logic               host_go;
    logic               launch;
    logic [IDX_W-1:0]   cfg_src_idx;
    logic [WORD_W-1:0]  cfg_dst;
    logic [CNT_W-1:0]   cfg_cnt;
    logic               mem_we;
    logic [IDX_W-1:0]   mem_idx;
    logic [WORD_W-1:0]  mem_wdata;
    logic [IDX_W-1:0]   rd_idx;
    logic [WORD_W-1:0]  rd_data;

    assign launch    = host_go || (wake_evt && arm);
    assign copy_done = done;

    bce_regs #(
        .ADDR_W     (ADDR_W),
        .SRAM_BASE  (SRAM_BASE),
        .SRAM_BYTES (SRAM_BYTES),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (host_wr_en),
        .addr        (host_addr),
        .wdata       (host_wdata),
        .busy        (busy),
        .done        (done),
        .rdata       (host_rdata),
        .arm         (arm),
        .host_go     (host_go),
        .cfg_src_idx (cfg_src_idx),
        .cfg_dst     (cfg_dst),
        .cfg_cnt     (cfg_cnt),
        .mem_we      (mem_we),
        .mem_idx     (mem_idx),
        .mem_wdata   (mem_wdata)
    );

    bce_sram #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_sram (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .we      (mem_we),
        .widx    (mem_idx),
        .wdata   (mem_wdata),
        .ridx    (rd_idx),
        .rd_data (rd_data)
    );

    bce_seq #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .cfg_src_idx (cfg_src_idx),
        .cfg_dst     (cfg_dst),
        .cfg_cnt     (cfg_cnt),
        .rd_data     (rd_data),
        .rd_idx      (rd_idx),
        .busy        (busy),
        .done        (done),
        .iram_we     (iram_we),
        .iram_addr   (iram_addr),
        .iram_wdata  (iram_wdata)
    );

    AST_WAKE_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (!arm && !host_go && !busy) |=> !iram_we)
        else $error("activity without a trigger"); // R8

endmodule

// File: tb/boot_copy_engine_tb.sv
module boot_copy_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wake = 1'b0;
    logic        iram_we;
    logic [31:0] iram_addr;
    logic [31:0] iram_wdata;
    logic        copy_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nwr = 0;
    int last_cyc = 0;
    logic [31:0] log_a [4096];
    logic [31:0] log_d [4096];
    int          log_c [4096];

    always #2 clk = ~clk;

    boot_copy_engine u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_wr_en (wr_en),
        .host_addr  (addr),
        .host_wdata (wdata),
        .host_rdata (rdata),
        .wake_evt   (wake),
        .iram_we    (iram_we),
        .iram_addr  (iram_addr),
        .iram_wdata (iram_wdata),
        .copy_done  (copy_done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (iram_we && nwr < 4096) begin
            log_a[nwr] = iram_addr;
            log_d[nwr] = iram_wdata;
            log_c[nwr] = cyc;
            nwr = nwr + 1;
        end
    end

    function automatic logic [31:0] pat(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {8'hC3, b, ~b, b ^ 8'h5A};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        #1;
        last_cyc = cyc;
        wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wake_pulse();
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        #1;
        last_cyc = cyc;
        wake = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            host_read(12'h000, v);
            if (v[31] == 1'b0) return;
        end
        check("R4 idle timeout", 32'd1, 32'd0);
    endtask

    // Verifies N logged writes starting at log index base
    task automatic check_words(input string tag, input int base, input int src_idx,
                               input int n, input logic [31:0] dst, input int first_cyc);
        check({tag, " count"}, 32'(nwr - base), 32'(n));
        for (int k = 0; k < n; k++) begin
            check({tag, " addr"}, log_a[base + k], dst + 32'(4 * k));
            check({tag, " data"}, log_d[base + k], pat((src_idx + k) % 256));
            check({tag, " cycle"}, 32'(log_c[base + k]), 32'(first_cyc + k));
        end
    endtask

    task automatic run_copy(input int src_idx, input int n, input logic [31:0] dst);
        logic [31:0] v;
        int base;
        host_write(12'h004, 32'(src_idx * 4));
        host_write(12'h008, dst);
        host_write(12'h00C, 32'(n));
        base = nwr;
        host_write(12'h000, 32'h8000_0000);
        #0;
        v = rdata;
        host_read(12'h010, v);
        if (n > 1) check("R6 done cleared at start", v, 32'd0);
        wait_idle();
        check_words("R5 sweep", base, src_idx, n, dst, last_cyc);
        host_read(12'h010, v);
        check("R6 done after copy", v, 32'd1);
        check("R6 copy_done pin", 32'(copy_done), 32'd1);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        int srcs [4];
        int cnts [5];
        srcs = '{0, 1, 100, 250};
        cnts = '{1, 2, 3, 7, 256};

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        host_read(12'h000, v); check("R1 ctrl", v, 32'd0);
        host_read(12'h004, v); check("R1 src", v, 32'd0);
        host_read(12'h008, v); check("R1 dst", v, 32'd0);
        host_read(12'h00C, v); check("R1 cnt", v, 32'd0);
        host_read(12'h010, v); check("R1 status", v, 32'd0);
        check("R1 iram_we", 32'(iram_we), 32'd0);
        check("R1 copy_done", 32'(copy_done), 32'd0);

        // R3 fill the retention SRAM through its window
        for (int i = 0; i < 256; i++) host_write(12'(12'h400 + 4 * i), pat(i));

        // R2 register readback and count masking
        host_write(12'h004, 32'h0000_0010); host_read(12'h004, v); check("R2 src", v, 32'h10);
        host_write(12'h008, 32'hABCD_0124); host_read(12'h008, v); check("R2 dst", v, 32'hABCD_0124);
        host_write(12'h00C, 32'hFFFF_FE05); host_read(12'h00C, v); check("R2 cnt mask", v, 32'h005);
        host_read(12'h000, v); check("R2 ctrl idle", v, 32'd0);

        // R7 zero count
        host_write(12'h00C, 32'd0);
        base = nwr;
        host_write(12'h000, 32'h8000_0000);
        host_read(12'h010, v); check("R7 done", v, 32'd1);
        host_read(12'h000, v); check("R7 go clear", v, 32'd0);
        repeat (3) @(negedge clk);
        check("R7 no writes", 32'(nwr - base), 32'd0);

        // R4 busy read while running
        host_write(12'h004, 32'd0);
        host_write(12'h008, 32'h0000_4000);
        host_write(12'h00C, 32'd6);
        host_write(12'h000, 32'h8000_0000);
        host_read(12'h000, v); check("R4 busy bit", v, 32'h8000_0000);
        wait_idle();
        host_read(12'h000, v); check("R4 busy cleared", v, 32'd0);

        // R5 sweep of source offsets and lengths (includes wrap)
        foreach (srcs[si]) begin
            foreach (cnts[ci]) begin
                run_copy(srcs[si], cnts[ci], 32'h0001_0000 + 32'(si) * 32'h1000);
            end
        end

        // R10 and R9: writes and retrigger during a copy
        host_write(12'h004, 32'd0);
        host_write(12'h008, 32'h0000_2000);
        host_write(12'h00C, 32'd40);
        base = nwr;
        host_write(12'h000, 32'h8000_0000);
        begin
            int first;
            first = last_cyc;
            host_write(12'h004, 32'h44);
            host_write(12'h008, 32'h9999);
            host_write(12'h00C, 32'd3);
            host_write(12'h478, 32'hDEAD_BEEF);
            host_write(12'h000, 32'h8000_0000);
            wait_idle();
            check_words("R9 R10 locked copy", base, 0, 40, 32'h0000_2000, first);
        end
        host_read(12'h004, v); check("R10 src kept", v, 32'd0);
        host_read(12'h008, v); check("R10 dst kept", v, 32'h2000);
        host_read(12'h00C, v); check("R10 cnt kept", v, 32'd40);
        base = nwr;
        host_write(12'h004, 32'd120);
        host_write(12'h00C, 32'd1);
        host_write(12'h000, 32'h8000_0000);
        wait_idle();
        check("R10 sram kept", log_d[base], pat(30));

        // R8 armed wake repeats the programmed copy
        host_write(12'h004, 32'd20);
        host_write(12'h008, 32'h0000_3000);
        host_write(12'h00C, 32'd4);
        base = nwr;
        host_write(12'h000, 32'h4000_0000);
        repeat (3) @(negedge clk);
        check("R8 arm alone idle", 32'(nwr - base), 32'd0);
        host_read(12'h000, v); check("R8 arm readback", v, 32'h4000_0000);
        for (int rep = 0; rep < 2; rep++) begin
            base = nwr;
            wake_pulse();
            begin
                int first;
                first = last_cyc;
                wait_idle();
                check_words("R8 wake copy", base, 5, 4, 32'h0000_3000, first);
            end
        end

        // R9 wake during a copy is ignored
        host_write(12'h00C, 32'd20);
        base = nwr;
        wake_pulse();
        begin
            int first;
            first = last_cyc;
            repeat (4) @(negedge clk);
            wake_pulse();
            wait_idle();
            check_words("R9 wake mid copy", base, 5, 20, 32'h0000_3000, first);
        end

        // R8 disarmed wake does nothing
        host_write(12'h000, 32'h0000_0000);
        base = nwr;
        wake_pulse();
        repeat (4) @(negedge clk);
        check("R8 unarmed wake", 32'(nwr - base), 32'd0);
        host_read(12'h010, v); check("R8 done kept", v, 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule